// File: doc/BRIEF.md
# Inbound PCI Target Address Translator

This block sits behind the target side of a PCI interface. When an external initiator hits one of six base address windows, it turns the PCI address into an address on the chip's internal bus. Four memory windows each cover 16 MB. Each one takes its own upper address byte from a packed 32-bit memory base register. One window covers a 256-byte I/O region and takes its upper 24 address bits from a separate I/O base register. The last window points at the controller's own control/status registers. That window never starts an internal bus cycle. It produces a one-cycle register-space select with an 8-bit offset instead.

The interface that completes the PCI transaction gives one hit strobe per access. The strobe comes with the window index, the PCI address, the command type and the read/write flag. The block registers the result. For a bus request it holds the request, the address, the direction and the window index until the downstream side acknowledges. During that time it reports busy and ignores new hits. A simple write port loads the two translation registers.

Top module: `pci_in_xlat`

## Requirements
- R1: After reset `req_o`, `busy_o`, `csr_sel_o` and `dec_err_o` are low, and both translation registers are zero. A memory hit on window 0 translates with upper byte 0x00, and an I/O hit on window 5 translates with upper 24 bits of zero.
- R2: A hit on window k (0 to 3) with a memory command (`is_io_i` = 0) requests address {B, `addr_i[23:0]`}. B is byte k of the memory base register, taken from bits 31:24 for k=0, 23:16 for k=1, 15:8 for k=2 and 7:0 for k=3.
- R3: A hit on window 5 with an I/O command (`is_io_i` = 1) requests address {I/O base[23:0], `addr_i[7:0]`}.
- R4: A hit on window 4 with a memory command raises no request. It pulses `csr_sel_o` for exactly one cycle, with `csr_off_o` = `addr_i[7:0]` and `csr_write_o` = `write_i`.
- R5: A hit with the wrong command type for its window, or a hit on index 6 or 7, pulses `dec_err_o` for one cycle. It raises neither a request nor a register-space select.
- R6: The results of an accepted hit appear on the outputs in the cycle after the clock edge that samples `hit_i`. A request carries `req_write_o` = `write_i` and `req_win_o` = the window index.
- R7: `req_o` stays high, with its address, direction and window held stable, until a clock edge at which `ack_i` is high. That edge clears it.
- R8: `busy_o` is high exactly while a request is pending. Hits sampled while busy, including the hit in the acknowledge cycle, are ignored: they produce no request, no select and no error.
- R9: The write port updates a register at the next clock edge. `cfg_sel_i` = 0 loads the memory base from `cfg_wdata_i[31:0]`, and `cfg_sel_i` = 1 loads the I/O base from `cfg_wdata_i[23:0]`. A hit sampled at the same edge as a write uses the old value. A request already captured keeps its address.
- R10: In any cycle at most one of these is true: `csr_sel_o`, `dec_err_o`, or a newly raised `req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Translation register write enable |
| cfg_sel_i | input | 1 | Write target: 0 memory base, 1 I/O base |
| cfg_wdata_i | input | 32 | Write data |
| hit_i | input | 1 | Window hit strobe |
| bar_i | input | 3 | Window index |
| addr_i | input | 32 | PCI address |
| is_io_i | input | 1 | Command type: 1 I/O, 0 memory |
| write_i | input | 1 | Access direction: 1 write |
| ack_i | input | 1 | Downstream acknowledge of the request |
| req_o | output | 1 | Internal bus request pending |
| req_addr_o | output | 32 | Translated address |
| req_write_o | output | 1 | Request direction |
| req_win_o | output | 3 | Window that produced the request |
| csr_sel_o | output | 1 | Register-space select pulse |
| csr_off_o | output | 8 | Register offset |
| csr_write_o | output | 1 | Register access direction |
| dec_err_o | output | 1 | Decode error pulse |
| busy_o | output | 1 | Request outstanding |

## Verification
The assertions check the handshake on every cycle: a pending request holds steady until acknowledged and drops after the acknowledge. They also check that hits arriving while busy cause no side effects, that at most one kind of outcome occurs per cycle, and that the write port loads the register at the next edge. The contents of the translation register and the bit placement of each window's byte are shown only by the bench, which compares each translated address against its own model. The same applies to the old-versus-new value when a write and a hit share an edge, and to the reset values.

// File: rtl/pxlat_pkg.sv
package pxlat_pkg;
  typedef enum logic [1:0] {
    DEC_BUS = 2'd0,
    DEC_CSR = 2'd1,
    DEC_ERR = 2'd2
  } dec_kind_e;
endpackage

// File: rtl/pxlat_regs.sv
module pxlat_regs #(
  parameter int ADDR_W      = 32,
  parameter int NUM_MEM_WIN = 4,
  parameter int MEM_HI_W    = 8,
  parameter int IO_HI_W     = 24
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic                            sel_i,
  input  logic [ADDR_W-1:0]               wdata_i,
  output logic [NUM_MEM_WIN*MEM_HI_W-1:0] mem_base_o,
  output logic [IO_HI_W-1:0]              io_base_o
);
  localparam int BASE_W = NUM_MEM_WIN * MEM_HI_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_base_o <= '0;
      io_base_o  <= '0;
    end else if (we_i) begin
      if (sel_i) io_base_o  <= wdata_i[IO_HI_W-1:0];
      else       mem_base_o <= wdata_i[BASE_W-1:0];
    end
  end

  // R9
  mem_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !sel_i |=> mem_base_o == $past(wdata_i[BASE_W-1:0]));

  // R9
  io_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && sel_i |=> io_base_o == $past(wdata_i[IO_HI_W-1:0]) && $stable(mem_base_o));
endmodule

// File: rtl/pxlat_decode.sv
module pxlat_decode import pxlat_pkg::*; #(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 3,
  parameter int NUM_MEM_WIN = 4,
  parameter int MEM_HI_W    = 8,
  parameter int IO_HI_W     = 24,
  parameter int CSR_WIN     = 4,
  parameter int IO_WIN      = 5
) (
  input  logic [IDX_W-1:0]                bar_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic                            is_io_i,
  input  logic [NUM_MEM_WIN*MEM_HI_W-1:0] mem_base_i,
  input  logic [IO_HI_W-1:0]              io_base_i,
  output dec_kind_e                       kind_o,
  output logic [ADDR_W-1:0]               xaddr_o
);
  localparam int MEM_LO_W = ADDR_W - MEM_HI_W;
  localparam int IO_LO_W  = ADDR_W - IO_HI_W;

  logic [MEM_HI_W-1:0]    win_hi [NUM_MEM_WIN];
  logic [NUM_MEM_WIN-1:0] win_hit;
  logic [MEM_HI_W-1:0]    sel_hi;
  logic                   io_hit, csr_hit, mem_hit;
  logic                   unused_hi;

  // window 0 owns the most significant byte
  for (genvar k = 0; k < NUM_MEM_WIN; k++) begin : g_win
    assign win_hi[k]  = mem_base_i[(NUM_MEM_WIN-1-k)*MEM_HI_W +: MEM_HI_W];
    assign win_hit[k] = (bar_i == IDX_W'(k));
  end

  always_comb begin
    sel_hi = '0;
    for (int k = 0; k < NUM_MEM_WIN; k++)
      if (win_hit[k]) sel_hi = sel_hi | win_hi[k];
  end

  assign mem_hit   = |win_hit;
  assign io_hit    = (bar_i == IDX_W'(IO_WIN));
  assign csr_hit   = (bar_i == IDX_W'(CSR_WIN));
  assign unused_hi = ^addr_i[ADDR_W-1:MEM_LO_W];

  always_comb begin
    if ((mem_hit && !is_io_i) || (io_hit && is_io_i)) kind_o = DEC_BUS;
    else if (csr_hit && !is_io_i)                     kind_o = DEC_CSR;
    else                                              kind_o = DEC_ERR;
  end

  assign xaddr_o = io_hit ? {io_base_i, addr_i[IO_LO_W-1:0]}
                          : {sel_hi, addr_i[MEM_LO_W-1:0]};
endmodule

// File: rtl/pxlat_out.sv
module pxlat_out import pxlat_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  dec_kind_e         kind_i,
  input  logic [ADDR_W-1:0] xaddr_i,
  input  logic              write_i,
  input  logic [IDX_W-1:0]  bar_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              req_write_o,
  output logic [IDX_W-1:0]  req_win_o,
  output logic              csr_sel_o,
  output logic [OFF_W-1:0]  csr_off_o,
  output logic              csr_write_o,
  output logic              dec_err_o,
  output logic              busy_o
);
  logic take;

  assign take   = hit_i && !req_o;
  assign busy_o = req_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o       <= 1'b0;
      req_addr_o  <= '0;
      req_write_o <= 1'b0;
      req_win_o   <= '0;
      csr_sel_o   <= 1'b0;
      csr_off_o   <= '0;
      csr_write_o <= 1'b0;
      dec_err_o   <= 1'b0;
    end else begin
      csr_sel_o <= take && (kind_i == DEC_CSR);
      dec_err_o <= take && (kind_i == DEC_ERR);
      if (take && kind_i == DEC_CSR) begin
        csr_off_o   <= off_i;
        csr_write_o <= write_i;
      end
      if (req_o) begin
        if (ack_i) req_o <= 1'b0;
      end else if (take && kind_i == DEC_BUS) begin
        req_o       <= 1'b1;
        req_addr_o  <= xaddr_i;
        req_write_o <= write_i;
        req_win_o   <= bar_i;
      end
    end
  end

  // R7
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(req_addr_o) && $stable(req_write_o) && $stable(req_win_o));

  // R7
  req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i |=> !req_o);

  // R8
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && hit_i |=> !csr_sel_o && !dec_err_o && !(req_o && !$past(req_o)));

  // R4
  csr_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_sel_o |-> !req_o);

  // R5
  err_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_err_o |-> !req_o && !csr_sel_o);

  // R10
  one_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({csr_sel_o, dec_err_o, req_o && !$past(req_o)}));

  // R6
  no_spont_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |=> !csr_sel_o && !dec_err_o);
endmodule

// File: rtl/pci_in_xlat.sv
module pci_in_xlat import pxlat_pkg::*; #(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 3,
  parameter int NUM_MEM_WIN = 4,
  parameter int MEM_HI_W    = 8,
  parameter int IO_HI_W     = 24,
  parameter int CSR_WIN     = 4,
  parameter int IO_WIN      = 5,
  parameter int OFF_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  input  logic              hit_i,
  input  logic [IDX_W-1:0]  bar_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              is_io_i,
  input  logic              write_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              req_write_o,
  output logic [IDX_W-1:0]  req_win_o,
  output logic              csr_sel_o,
  output logic [OFF_W-1:0]  csr_off_o,
  output logic              csr_write_o,
  output logic              dec_err_o,
  output logic              busy_o
);
  localparam int BASE_W = NUM_MEM_WIN * MEM_HI_W;

  logic [BASE_W-1:0]  mem_base;
  logic [IO_HI_W-1:0] io_base;
  dec_kind_e          kind;
  logic [ADDR_W-1:0]  xaddr;

  pxlat_regs #(
    .ADDR_W(ADDR_W), .NUM_MEM_WIN(NUM_MEM_WIN), .MEM_HI_W(MEM_HI_W), .IO_HI_W(IO_HI_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .sel_i(cfg_sel_i),
    .wdata_i(cfg_wdata_i), .mem_base_o(mem_base), .io_base_o(io_base)
  );

  pxlat_decode #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .NUM_MEM_WIN(NUM_MEM_WIN), .MEM_HI_W(MEM_HI_W),
    .IO_HI_W(IO_HI_W), .CSR_WIN(CSR_WIN), .IO_WIN(IO_WIN)
  ) u_dec (
    .bar_i(bar_i), .addr_i(addr_i), .is_io_i(is_io_i), .mem_base_i(mem_base),
    .io_base_i(io_base), .kind_o(kind), .xaddr_o(xaddr)
  );

  pxlat_out #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit_i), .kind_i(kind), .xaddr_i(xaddr),
    .write_i(write_i), .bar_i(bar_i), .off_i(addr_i[OFF_W-1:0]), .ack_i(ack_i),
    .req_o(req_o), .req_addr_o(req_addr_o), .req_write_o(req_write_o),
    .req_win_o(req_win_o), .csr_sel_o(csr_sel_o), .csr_off_o(csr_off_o),
    .csr_write_o(csr_write_o), .dec_err_o(dec_err_o), .busy_o(busy_o)
  );
endmodule

// File: tb/pci_in_xlat_bench.sv
module pci_in_xlat_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        hit = 1'b0;
  logic [2:0]  bar = '0;
  logic [31:0] addr = '0;
  logic        is_io = 1'b0, wr = 1'b0, ack = 1'b0;
  logic        req, req_wr, csr_sel, csr_wr, dec_err, busy;
  logic [31:0] req_addr;
  logic [2:0]  req_win;
  logic [7:0]  csr_off;

  pci_in_xlat u_pci_in_xlat (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .hit_i(hit), .bar_i(bar), .addr_i(addr),
    .is_io_i(is_io), .write_i(wr), .ack_i(ack), .req_o(req), .req_addr_o(req_addr),
    .req_write_o(req_wr), .req_win_o(req_win), .csr_sel_o(csr_sel),
    .csr_off_o(csr_off), .csr_write_o(csr_wr), .dec_err_o(dec_err), .busy_o(busy)
  );

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] m_mem = '0;
  logic [23:0] m_io  = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // 0 bus, 1 register space, 2 error
  function automatic int exp_kind(logic [2:0] b, logic io);
    if (b < 3'd4 && !io) return 0;
    if (b == 3'd5 && io) return 0;
    if (b == 3'd4 && !io) return 1;
    return 2;
  endfunction

  function automatic logic [31:0] exp_addr(logic [2:0] b, logic [31:0] a);
    logic [7:0] hi;
    if (b == 3'd5) return {m_io, a[7:0]};
    hi = 8'((m_mem >> (8 * (3 - int'(b)))) & 32'hff);
    return {hi, a[23:0]};
  endfunction

  task automatic cfg(input logic s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (s) m_io = d[23:0]; else m_mem = d;
  endtask

  task automatic issue(input logic [2:0] b, input logic [31:0] a, input logic io,
                       input logic w, input int dly);
    int k;
    logic [31:0] ea;
    string tag;
    @(negedge clk);
    hit = 1'b1; bar = b; addr = a; is_io = io; wr = w;
    k  = exp_kind(b, io);
    ea = exp_addr(b, a);
    tag = (k == 1) ? "R4" : (k == 2) ? "R5" : (b == 3'd5) ? "R3" : "R2";
    chk({"R6 idle before edge ", tag}, {29'd0, req, csr_sel, dec_err}, 32'd0);
    @(negedge clk);
    hit = 1'b0;
    if (k == 0) begin
      chk({tag, " req"}, {31'd0, req}, 32'd1);
      chk({tag, " addr"}, req_addr, ea);
      chk({"R6 write ", tag}, {31'd0, req_wr}, {31'd0, w});
      chk({"R6 win ", tag}, {29'd0, req_win}, {29'd0, b});
      chk({"R8 busy ", tag}, {31'd0, busy}, 32'd1);
      chk({"R10 ", tag}, {30'd0, csr_sel, dec_err}, 32'd0);
      for (int i = 0; i < dly; i++) begin
        @(negedge clk);
        chk("R7 held", {31'd0, req}, 32'd1);
        chk("R7 addr stable", req_addr, ea);
      end
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      chk("R7 drop on ack", {30'd0, req, busy}, 32'd0);
    end else if (k == 1) begin
      chk("R4 sel", {31'd0, csr_sel}, 32'd1);
      chk("R4 off", {24'd0, csr_off}, {24'd0, a[7:0]});
      chk("R4 write", {31'd0, csr_wr}, {31'd0, w});
      chk("R4 no req", {30'd0, req, dec_err}, 32'd0);
      @(negedge clk);
      chk("R4 one cycle", {31'd0, csr_sel}, 32'd0);
    end else begin
      chk("R5 err", {31'd0, dec_err}, 32'd1);
      chk("R5 no req", {30'd0, req, csr_sel}, 32'd0);
      @(negedge clk);
      chk("R5 one cycle", {31'd0, dec_err}, 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] hold_a;
    void'($urandom(32'h0000_5eed));
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {28'd0, req, busy, csr_sel, dec_err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {28'd0, req, busy, csr_sel, dec_err}, 32'd0);
    issue(3'd0, 32'hABCD_EF12, 1'b0, 1'b0, 0);   // R1: upper byte 0x00
    issue(3'd5, 32'h1234_5699, 1'b1, 1'b1, 0);   // R1: io base zero

    cfg(1'b0, 32'h1122_3344);
    cfg(1'b1, 32'hFFA5_B6C7);                    // R9: upper 8 bits dropped
    for (int b = 0; b < 4; b++) issue(3'(b), 32'h5A00_0000 | 32'(b * 16'h1357), 1'b0, b[0], 1); // R2
    issue(3'd5, 32'hFFFF_FF3C, 1'b1, 1'b0, 2);   // R3
    issue(3'd4, 32'h0000_01E8, 1'b0, 1'b1, 0);   // R4
    issue(3'd2, 32'h0000_0010, 1'b1, 1'b0, 0);   // R5 io on memory window
    issue(3'd5, 32'h0000_0010, 1'b0, 1'b0, 0);   // R5 memory on io window
    issue(3'd4, 32'h0000_0010, 1'b1, 1'b0, 0);   // R5 io on register window
    issue(3'd6, 32'h0000_0010, 1'b0, 1'b0, 0);   // R5
    issue(3'd7, 32'h0000_0010, 1'b1, 1'b0, 0);   // R5

    // R8: hits while busy are ignored; R9: write while pending
    @(negedge clk);
    hit = 1'b1; bar = 3'd1; addr = 32'h0012_3456; is_io = 1'b0; wr = 1'b1;
    @(negedge clk);
    hold_a = {8'h22, 24'h12_3456};
    chk("R2 busy setup addr", req_addr, hold_a);
    bar = 3'd4; addr = 32'h0000_0077;
    @(negedge clk);
    chk("R8 csr ignored", {31'd0, csr_sel}, 32'd0);
    chk("R8 addr kept", req_addr, hold_a);
    bar = 3'd7;
    @(negedge clk);
    chk("R8 err ignored", {31'd0, dec_err}, 32'd0);
    bar = 3'd3; is_io = 1'b0;
    @(negedge clk);
    chk("R8 win kept", {29'd0, req_win}, 32'd1);
    hit = 1'b0; cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    cfg_we = 1'b0; m_mem = 32'hDEAD_BEEF;
    chk("R9 captured addr kept", req_addr, hold_a);
    ack = 1'b1; hit = 1'b1; bar = 3'd4; is_io = 1'b0;
    @(negedge clk);
    ack = 1'b0; hit = 1'b0;
    chk("R8 ack cycle hit ignored", {29'd0, req, csr_sel, dec_err}, 32'd0);
    @(negedge clk);
    chk("R8 no late select", {31'd0, csr_sel}, 32'd0);

    // R9: write and hit on the same edge use the old value
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'h7700_0000;
    hit = 1'b1; bar = 3'd0; addr = 32'h00AB_CDEF; is_io = 1'b0; wr = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; hit = 1'b0;
    chk("R9 same edge old value", req_addr, 32'hDEAB_CDEF);
    m_mem = 32'h7700_0000;
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    issue(3'd0, 32'h00AB_CDEF, 1'b0, 1'b0, 0);   // R9 new value next

    for (int i = 0; i < 400; i++) begin
      logic [2:0] b;
      logic io;
      b  = 3'($urandom_range(0, 7));
      io = (b == 3'd5) ? ($urandom_range(0, 9) != 0) : ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 7) == 0) cfg(1'($urandom_range(0, 1)), $urandom);
      issue(b, $urandom, io, 1'($urandom_range(0, 1)), int'($urandom_range(0, 3)));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule